// File: doc/BRIEF.md
# Exception Vector Entry Controller

This block decides where a small 32-bit processor core branches when a reset, a general exception or an interrupt is raised, and produces the status-register and vector-base values that take effect on entry. Each cycle it samples the pending requests together with the core's current status register (`sr_i`) and vector base (`vbr_i`), selects at most one event, and one cycle later presents the branch target with a single-cycle valid strobe. It also presents the event code for the exception-event register and the updated status and vector base values.

Reset-class events always go to the fixed address 0xA000_0000 and restore the post-reset register values. General exceptions and interrupts are vectored relative to the vector base. The block bit in the status register changes this. A general exception raised while the block bit is set and not flagged as a user break is escalated into a reset. A flagged user break in that state is dropped. Interrupts wait until the block bit is clear. When no event is taken, the address, code, status and vector-base outputs keep the values from the last accepted event.

Top module: `exc_vector_ctrl`

## Requirements
- R1: While `rst_ni` is low and afterwards until the first accepted event, `vec_valid_o` is 0, `vec_addr_o` is 0xA000_0000, `exc_code_o` is 0x000, `vbr_o` is 0 and `sr_o` is 0x7000_00F0. Status bit positions: MD=30, RB=29, BL=28, FD=15, IMASK=7:4.
- R2: A sampled `por_req_i` gives, one cycle later, `vec_valid_o`=1, target 0xA000_0000, code 0x000, `vbr_o`=0 and `sr_o`=0x7000_00F0. This holds whatever the other inputs are.
- R3: A sampled `mrst_req_i` without power-on reset gives the same result as R2 except that the code is 0x020.
- R4: A general exception taken with BL=0 gives target `vbr_i`+0x100 and code `gexc_code_i`. It also gives `vbr_o`=`vbr_i` and `sr_o`=`sr_i` with MD, RB and BL set. Every strobe carries MD, RB and BL set in `sr_o`.
- R5: A general exception with BL=1 and `ubrk_i`=0 is escalated to a reset. It gives target 0xA000_0000, code 0x020, `vbr_o`=0 and `sr_o`=0x7000_00F0.
- R6: A general exception with BL=1 and `ubrk_i`=1 is ignored. No strobe follows and the outputs hold.
- R7: An interrupt is taken only if BL=0 and `irq_lvl_i` is strictly greater than `sr_i[7:4]`. It then gives target `vbr_i`+0x600 and code `irq_code_i`, with the same status and vector-base update as R4.
- R8: An interrupt with BL=1, or with a level at or below IMASK, produces no strobe and changes no output.
- R9: Only one event is taken per cycle. The order is power-on reset, then manual reset, then general exception, then interrupt.
- R10: `vec_valid_o` is high for exactly the cycle after each accepted event and low otherwise. When it is low, all other outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| por_req_i | input | 1 | Power-on reset request |
| mrst_req_i | input | 1 | Manual reset request |
| gexc_req_i | input | 1 | General exception request |
| gexc_code_i | input | 12 | Code of the requested general exception |
| ubrk_i | input | 1 | The general exception is a user break |
| irq_req_i | input | 1 | Interrupt request |
| irq_lvl_i | input | 4 | Interrupt priority level |
| irq_code_i | input | 12 | Code of the requesting interrupt source |
| sr_i | input | 32 | Current status register |
| vbr_i | input | 32 | Current vector base register |
| vec_valid_o | output | 1 | One-cycle branch strobe |
| vec_addr_o | output | 32 | Branch target address |
| exc_code_o | output | 12 | Code of the accepted event |
| sr_o | output | 32 | Status register value on entry |
| vbr_o | output | 32 | Vector base value on entry |

## Verification
The assertions check these rules on every cycle:
- the outcome of every power-on reset;
- escalation of a blocked general exception and dropping of a blocked user break;
- that masked interrupts are suppressed and that accepted interrupts are vectored;
- that the entry bits are set on each strobe;
- that the outputs hold between strobes.

Only the bench scenarios show the rest:
- the exact priority order when several requests arrive together;
- boundary cases such as an interrupt level equal to IMASK against one level above it;
- manual-reset codes;
- carry-through of the vector-base addition with large base values.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int SR_MD_BIT    = 30;
  localparam int SR_RB_BIT    = 29;
  localparam int SR_BL_BIT    = 28;
  localparam int SR_FD_BIT    = 15;
  localparam int SR_IMASK_LSB = 4;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_POR,
    EV_MRST,
    EV_ESCALATE,
    EV_GEXC,
    EV_IRQ
  } ev_kind_e;
endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_vec_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             por_i,
  input  logic             mrst_i,
  input  logic             gexc_i,
  input  logic             ubrk_i,
  input  logic             irq_i,
  input  logic             bl_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] imask_i,
  output ev_kind_e         kind_o
);
  logic irq_ok;
  assign irq_ok = irq_i && !bl_i && (lvl_i > imask_i);

  always_comb begin
    kind_o = EV_NONE;
    if (por_i)                  kind_o = EV_POR;
    else if (mrst_i)            kind_o = EV_MRST;
    else if (gexc_i && !bl_i)   kind_o = EV_GEXC;
    else if (gexc_i && !ubrk_i) kind_o = EV_ESCALATE;
    else if (gexc_i)            kind_o = EV_NONE; // blocked user break dropped
    else if (irq_ok)            kind_o = EV_IRQ;
  end
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
  import exc_vec_pkg::*;
#(
  parameter int                 DATA_W     = 32,
  parameter int                 CODE_W     = 12,
  parameter int                 LVL_W      = 4,
  parameter logic [DATA_W-1:0]  RESET_ADDR = 32'hA000_0000,
  parameter logic [DATA_W-1:0]  GEXC_OFF   = 32'h0000_0100,
  parameter logic [DATA_W-1:0]  IRQ_OFF    = 32'h0000_0600,
  parameter logic [CODE_W-1:0]  POR_CODE   = 12'h000,
  parameter logic [CODE_W-1:0]  MRST_CODE  = 12'h020
) (
  input  ev_kind_e            kind_i,
  input  logic [DATA_W-1:0]   sr_i,
  input  logic [DATA_W-1:0]   vbr_i,
  input  logic [CODE_W-1:0]   gexc_code_i,
  input  logic [CODE_W-1:0]   irq_code_i,
  output logic                take_o,
  output logic [DATA_W-1:0]   addr_o,
  output logic [CODE_W-1:0]   code_o,
  output logic [DATA_W-1:0]   sr_o,
  output logic [DATA_W-1:0]   vbr_o
);
  localparam logic [DATA_W-1:0] ENTRY_MASK =
      (DATA_W'(1) << SR_MD_BIT) | (DATA_W'(1) << SR_RB_BIT) | (DATA_W'(1) << SR_BL_BIT);
  localparam logic [DATA_W-1:0] SR_RESET =
      ENTRY_MASK | (DATA_W'({LVL_W{1'b1}}) << SR_IMASK_LSB);

  always_comb begin
    take_o = 1'b1;
    addr_o = RESET_ADDR;
    code_o = POR_CODE;
    sr_o   = SR_RESET;
    vbr_o  = '0;
    unique case (kind_i)
      EV_POR: ;
      EV_MRST, EV_ESCALATE: code_o = MRST_CODE;
      EV_GEXC: begin
        addr_o = vbr_i + GEXC_OFF;
        code_o = gexc_code_i;
        sr_o   = sr_i | ENTRY_MASK;
        vbr_o  = vbr_i;
      end
      EV_IRQ: begin
        addr_o = vbr_i + IRQ_OFF;
        code_o = irq_code_i;
        sr_o   = sr_i | ENTRY_MASK;
        vbr_o  = vbr_i;
      end
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl
  import exc_vec_pkg::*;
#(
  parameter int                 DATA_W     = 32,
  parameter int                 CODE_W     = 12,
  parameter int                 LVL_W      = 4,
  parameter logic [DATA_W-1:0]  RESET_ADDR = 32'hA000_0000,
  parameter logic [DATA_W-1:0]  GEXC_OFF   = 32'h0000_0100,
  parameter logic [DATA_W-1:0]  IRQ_OFF    = 32'h0000_0600,
  parameter logic [CODE_W-1:0]  POR_CODE   = 12'h000,
  parameter logic [CODE_W-1:0]  MRST_CODE  = 12'h020
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_req_i,
  input  logic              mrst_req_i,
  input  logic              gexc_req_i,
  input  logic [CODE_W-1:0] gexc_code_i,
  input  logic              ubrk_i,
  input  logic              irq_req_i,
  input  logic [LVL_W-1:0]  irq_lvl_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic [DATA_W-1:0] sr_i,
  input  logic [DATA_W-1:0] vbr_i,
  output logic              vec_valid_o,
  output logic [DATA_W-1:0] vec_addr_o,
  output logic [CODE_W-1:0] exc_code_o,
  output logic [DATA_W-1:0] sr_o,
  output logic [DATA_W-1:0] vbr_o
);
  localparam logic [DATA_W-1:0] SR_RESET =
      (DATA_W'(1) << SR_MD_BIT) | (DATA_W'(1) << SR_RB_BIT) | (DATA_W'(1) << SR_BL_BIT) |
      (DATA_W'({LVL_W{1'b1}}) << SR_IMASK_LSB);

  ev_kind_e          kind;
  logic              take;
  logic [DATA_W-1:0] addr_n, sr_n, vbr_n;
  logic [CODE_W-1:0] code_n;
  logic              bl;
  logic [LVL_W-1:0]  imask;

  assign bl    = sr_i[SR_BL_BIT];
  assign imask = sr_i[SR_IMASK_LSB +: LVL_W];

  exc_vector_sel #(.LVL_W(LVL_W)) u_sel (
    .por_i   (por_req_i),
    .mrst_i  (mrst_req_i),
    .gexc_i  (gexc_req_i),
    .ubrk_i  (ubrk_i),
    .irq_i   (irq_req_i),
    .bl_i    (bl),
    .lvl_i   (irq_lvl_i),
    .imask_i (imask),
    .kind_o  (kind)
  );

  exc_vector_calc #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .LVL_W(LVL_W),
    .RESET_ADDR(RESET_ADDR), .GEXC_OFF(GEXC_OFF), .IRQ_OFF(IRQ_OFF),
    .POR_CODE(POR_CODE), .MRST_CODE(MRST_CODE)
  ) u_calc (
    .kind_i      (kind),
    .sr_i        (sr_i),
    .vbr_i       (vbr_i),
    .gexc_code_i (gexc_code_i),
    .irq_code_i  (irq_code_i),
    .take_o      (take),
    .addr_o      (addr_n),
    .code_o      (code_n),
    .sr_o        (sr_n),
    .vbr_o       (vbr_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      vec_addr_o  <= RESET_ADDR;
      exc_code_o  <= POR_CODE;
      sr_o        <= SR_RESET;
      vbr_o       <= '0;
    end else begin
      vec_valid_o <= take;
      if (take) begin
        vec_addr_o <= addr_n;
        exc_code_o <= code_n;
        sr_o       <= sr_n;
        vbr_o      <= vbr_n;
      end
    end
  end

  // one cycle of history is valid only after the first clocked cycle
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assert_por_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(por_req_i) |-> vec_valid_o && vec_addr_o == RESET_ADDR &&
      exc_code_o == POR_CODE && vbr_o == '0 && sr_o == SR_RESET);

  assert_entry_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT] && sr_o[SR_BL_BIT]);

  assert_escalate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(gexc_req_i && !por_req_i && !mrst_req_i && sr_i[SR_BL_BIT] && !ubrk_i)
      |-> vec_valid_o && vec_addr_o == RESET_ADDR && exc_code_o == MRST_CODE && vbr_o == '0);

  assert_ubrk_dropped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(gexc_req_i && !por_req_i && !mrst_req_i && sr_i[SR_BL_BIT] && ubrk_i)
      |-> !vec_valid_o);

  assert_irq_taken_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(irq_req_i && !por_req_i && !mrst_req_i && !gexc_req_i &&
                    !sr_i[SR_BL_BIT] && (irq_lvl_i > sr_i[SR_IMASK_LSB +: LVL_W]))
      |-> vec_valid_o && vec_addr_o == $past(vbr_i) + IRQ_OFF);

  assert_irq_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(irq_req_i && !por_req_i && !mrst_req_i && !gexc_req_i &&
                    (sr_i[SR_BL_BIT] || (irq_lvl_i <= sr_i[SR_IMASK_LSB +: LVL_W])))
      |-> !vec_valid_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && !vec_valid_o |-> $stable(vec_addr_o) && $stable(exc_code_o) &&
      $stable(sr_o) && $stable(vbr_o));
endmodule

// File: tb/exc_vector_ctrl_test.sv
module exc_vector_ctrl_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_ni;
  logic        por, mrst, gexc, ubrk, irq;
  logic [11:0] gcode, icode;
  logic [3:0]  lvl;
  logic [31:0] sr, vbr;
  logic        v_o;
  logic [31:0] a_o, s_o, b_o;
  logic [11:0] c_o;

  int checks = 0;
  int errors = 0;

  exc_vector_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .por_req_i(por), .mrst_req_i(mrst), .gexc_req_i(gexc), .gexc_code_i(gcode),
    .ubrk_i(ubrk), .irq_req_i(irq), .irq_lvl_i(lvl), .irq_code_i(icode),
    .sr_i(sr), .vbr_i(vbr),
    .vec_valid_o(v_o), .vec_addr_o(a_o), .exc_code_o(c_o), .sr_o(s_o), .vbr_o(b_o)
  );

  typedef struct packed {
    logic        v;
    logic [31:0] a;
    logic [11:0] c;
    logic [31:0] s;
    logic [31:0] b;
  } exp_t;

  localparam logic [31:0] SR_RST = 32'h7000_00F0;
  localparam logic [31:0] ENTRY  = 32'h7000_0000;
  localparam exp_t RST_EXP = '{v: 1'b0, a: 32'hA000_0000, c: 12'h000, s: SR_RST, b: 32'h0};

  exp_t  exp_q;
  string tag_q;

  function automatic exp_t model(input exp_t prev, input logic p, input logic m,
      input logic g, input logic [11:0] gc, input logic u, input logic i,
      input logic [3:0] l, input logic [11:0] ic, input logic [31:0] s,
      input logic [31:0] b, output string tag);
    exp_t e = prev;
    logic blk = s[28];
    e.v = 1'b0;
    if (p) begin
      e = '{v: 1'b1, a: 32'hA000_0000, c: 12'h000, s: SR_RST, b: 32'h0}; tag = "R2";
    end else if (m) begin
      e = '{v: 1'b1, a: 32'hA000_0000, c: 12'h020, s: SR_RST, b: 32'h0}; tag = "R3";
    end else if (g && !blk) begin
      e = '{v: 1'b1, a: b + 32'h100, c: gc, s: s | ENTRY, b: b}; tag = "R4";
    end else if (g && !u) begin
      e = '{v: 1'b1, a: 32'hA000_0000, c: 12'h020, s: SR_RST, b: 32'h0}; tag = "R5";
    end else if (g) begin
      tag = "R6";
    end else if (i && !blk && l > s[7:4]) begin
      e = '{v: 1'b1, a: b + 32'h600, c: ic, s: s | ENTRY, b: b}; tag = "R7";
    end else if (i) begin
      tag = "R8";
    end else begin
      tag = "R10";
    end
    return e;
  endfunction

  task automatic check(input string tag, input exp_t e);
    exp_t act = '{v: v_o, a: a_o, c: c_o, s: s_o, b: b_o};
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual v=%0b a=%h c=%h sr=%h vbr=%h expected v=%0b a=%h c=%h sr=%h vbr=%h",
               tag, act.v, act.a, act.c, act.s, act.b, e.v, e.a, e.c, e.s, e.b);
    end
  endtask

  task automatic apply(input logic p, input logic m, input logic g, input logic [11:0] gc,
      input logic u, input logic i, input logic [3:0] l, input logic [11:0] ic,
      input logic [31:0] s, input logic [31:0] b);
    @(negedge clk);
    check(tag_q, exp_q);
    por = p; mrst = m; gexc = g; gcode = gc; ubrk = u;
    irq = i; lvl = l; icode = ic; sr = s; vbr = b;
    exp_q = model(exp_q, p, m, g, gc, u, i, l, ic, s, b, tag_q);
  endtask

  task automatic idle();
    apply(0, 0, 0, 12'h0, 0, 0, 4'h0, 12'h0, 32'h0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_ni = 1'b0;
    {por, mrst, gexc, ubrk, irq} = '0;
    gcode = '0; icode = '0; lvl = '0; sr = '0; vbr = '0;
    repeat (3) @(negedge clk);
    check("R1", RST_EXP);
    rst_ni = 1'b1;
    exp_q = RST_EXP;
    tag_q = "R1";
    idle();
    // R2 + R9: all requests at once, power-on wins
    apply(1, 1, 1, 12'h1E0, 0, 1, 4'hF, 12'hA00, 32'h0000_0000, 32'h8000_0000);
    // R3 + R9: manual reset beats general exception
    apply(0, 1, 1, 12'h1E0, 0, 1, 4'hF, 12'hA00, 32'h0000_0000, 32'h8000_0000);
    // R4: BL clear, vectored; R9: exception beats interrupt
    apply(0, 0, 1, 12'h180, 0, 1, 4'hF, 12'hA00, 32'h0000_8030, 32'h8C00_0000);
    idle(); // R10 hold
    // R5: blocked non-break exception escalates
    apply(0, 0, 1, 12'h180, 0, 0, 4'h0, 12'h0, 32'h1000_0000, 32'h8C00_0000);
    // R6: blocked user break dropped
    apply(0, 0, 1, 12'h1E0, 1, 1, 4'hF, 12'hA00, 32'h1000_0000, 32'h8C00_0000);
    // R8: level equal to IMASK
    apply(0, 0, 0, 12'h0, 0, 1, 4'h5, 12'hAE0, 32'h0000_0050, 32'h1234_0000);
    // R7: level one above IMASK
    apply(0, 0, 0, 12'h0, 0, 1, 4'h6, 12'hAE0, 32'h0000_0050, 32'h1234_0000);
    // R8: BL set blocks highest level
    apply(0, 0, 0, 12'h0, 0, 1, 4'hF, 12'hA00, 32'h1000_0000, 32'h1234_0000);
    // R7: carry through vector add
    apply(0, 0, 0, 12'h0, 0, 1, 4'h1, 12'hA00, 32'h0000_0000, 32'hFFFF_FC00);
    // R4 again back to back
    apply(0, 0, 1, 12'h0C0, 1, 0, 4'h0, 12'h0, 32'h4000_0000, 32'h0000_0F00);
    idle();
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rs;
      rs = $urandom;
      rs[28] = ($urandom % 3) == 0;
      apply(($urandom % 20) == 0, ($urandom % 20) == 0, ($urandom % 4) == 0,
            12'($urandom), ($urandom % 2) == 0, ($urandom % 2) == 0, 4'($urandom),
            12'($urandom), rs, $urandom);
    end
    idle();
    idle();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule